// File: doc/BRIEF.md
# Integer Clock Divider with Balanced Duty Cycle

This block derives a slower clock from an input clock by a whole-number ratio N, where N is the input frequency over the output frequency. The ratio comes from a static input, and the output has a 50% duty cycle whether N is even or odd. For example, a 50 MHz input with N = 10 gives 5 MHz, and with N = 5 it gives 10 MHz.

An even ratio uses one counter clocked on the rising edge, which sets and clears a single phase flop. An odd ratio cannot be balanced on one edge. It therefore uses two matching counters: one advances on rising edges and the other on falling edges. The two phase flops are ORed, so the half-period lag of the second one stretches the high time to exactly N/2 input periods. A ratio of 0 or 1 passes the input clock straight through. The least significant bit of the effective ratio picks the even or the odd path. The ratio is meant to change only while reset is held.

Top module: `clk_div_int`

## Requirements
- R1: A ratio of 0 or 1 is treated as 1: the output follows the input clock, with a 10 ns period and a 5 ns high time for a 100 MHz input.
- R2: Each counter wraps to 0 after reaching N-1 and never holds a value above N-1.
- R3: For even N, the output period is N input periods and the high time is N/2 input periods. The output changes only on rising input edges, at the edges where the counter stands at N/2-1 (output goes high) or at N-1 (output goes low).
- R4: For odd N of 3 or more, the output period is N input periods and the high time is exactly N/2 input periods (N half-periods).
- R5: While the active-low asynchronous reset is low, the output is low for every ratio, including the pass-through case, and all counters and phase flops are cleared.
- R6: If reset is released while the input clock is low, the first output rising edge coincides with rising input edge number k after release. Here k is 1 for N = 1, N/2 for even N, and N for odd N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio | input | RATIO_W | Division ratio N (static; 0 is treated as 1) |
| clk_out | output | 1 | Divided clock, 50% duty cycle |

## Verification
The bench sweeps every ratio from 0 to 17. This covers the pass-through values 0 and 1, the smallest even and odd ratios 2 and 3, and a run of alternating parities. Time stamps of output edges separate a wrong toggle count (period error) from a wrong set or clear point (high-time error). They also separate a missing falling-edge contribution, which leaves an odd high time short by half a period, from an off-by-one start-up latency. Sampling during reset at both clock levels shows whether the pass-through path is gated.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Which output path the effective ratio selects.
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_EVEN   = 2'd1,
        MODE_ODD    = 2'd2
    } div_mode_e;

endpackage

// File: rtl/clkdiv_plan.sv
// Decodes the static ratio into a path choice and the counts at which the
// phase flops are set, cleared and the counters wrap.
module clkdiv_plan
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic [RATIO_W-1:0] ratio,
    output div_mode_e          mode,
    output logic [RATIO_W-1:0] last_cnt,
    output logic [RATIO_W-1:0] set_cnt,
    output logic [RATIO_W-1:0] clr_cnt
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] n_eff;

    always_comb begin
        n_eff    = (ratio == '0) ? ONE : ratio;
        last_cnt = n_eff - ONE;
        mode     = MODE_BYPASS;
        set_cnt  = '0;
        clr_cnt  = '0;
        if (n_eff == ONE) begin
            mode = MODE_BYPASS;
        end else if (n_eff[0] == 1'b0) begin
            // even: high at N/2-1, low at N-1
            mode    = MODE_EVEN;
            set_cnt = (n_eff >> 1) - ONE;
            clr_cnt = last_cnt;
        end else begin
            // odd: high at wrap, low at (N-1)/2-1 -> high for (N-1)/2 cycles
            mode    = MODE_ODD;
            set_cnt = last_cnt;
            clr_cnt = (last_cnt >> 1) - ONE;
        end
    end

endmodule

// File: rtl/clkdiv_phase_gen.sv
// Wrapping counter plus a phase flop, clocked on the edge FALL_EDGE selects.
module clkdiv_phase_gen #(
    parameter int RATIO_W   = 8,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [RATIO_W-1:0] last_cnt,
    input  logic [RATIO_W-1:0] set_cnt,
    input  logic [RATIO_W-1:0] clr_cnt,
    output logic               phase,
    output logic [RATIO_W-1:0] cnt
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               phase;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + RATIO_W'(1);
            end
            if (st_q.cnt == set_cnt) begin
                st_d.phase = 1'b1;
            end else if (st_q.cnt == clr_cnt) begin
                st_d.phase = 1'b0;
            end
        end
    end

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    assign phase = st_q.phase;
    assign cnt   = st_q.cnt;

endmodule

// File: rtl/clk_div_int.sv
// Integer clock divider, 50% duty for even and odd ratios.
module clk_div_int
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);

    div_mode_e          mode;
    logic [RATIO_W-1:0] last_cnt;
    logic [RATIO_W-1:0] set_cnt;
    logic [RATIO_W-1:0] clr_cnt;
    logic               rise_ph;
    logic               fall_ph;
    logic [RATIO_W-1:0] rise_cnt;
    logic [RATIO_W-1:0] fall_cnt;
    logic               rise_en;
    logic               fall_en;

    clkdiv_plan #(.RATIO_W(RATIO_W)) u_plan (
        .ratio    (ratio),
        .mode     (mode),
        .last_cnt (last_cnt),
        .set_cnt  (set_cnt),
        .clr_cnt  (clr_cnt)
    );

    assign rise_en = (mode != MODE_BYPASS);
    assign fall_en = (mode == MODE_ODD);

    clkdiv_phase_gen #(.RATIO_W(RATIO_W), .FALL_EDGE(1'b0)) u_rise (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .enable   (rise_en),
        .last_cnt (last_cnt),
        .set_cnt  (set_cnt),
        .clr_cnt  (clr_cnt),
        .phase    (rise_ph),
        .cnt      (rise_cnt)
    );

    clkdiv_phase_gen #(.RATIO_W(RATIO_W), .FALL_EDGE(1'b1)) u_fall (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .enable   (fall_en),
        .last_cnt (last_cnt),
        .set_cnt  (set_cnt),
        .clr_cnt  (clr_cnt),
        .phase    (fall_ph),
        .cnt      (fall_cnt)
    );

    always_comb begin
        unique case (mode)
            MODE_EVEN: clk_out = rise_ph;
            MODE_ODD:  clk_out = rise_ph | fall_ph;
            default:   clk_out = clk_in & rst_n;
        endcase
    end

endmodule

// File: rtl/clk_div_int_chk.sv
module clk_div_int_chk
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input logic               clk_in,
    input logic               rst_n,
    input logic               clk_out,
    input div_mode_e          mode,
    input logic [RATIO_W-1:0] last_cnt,
    input logic [RATIO_W-1:0] set_cnt,
    input logic [RATIO_W-1:0] clr_cnt,
    input logic [RATIO_W-1:0] rise_cnt,
    input logic [RATIO_W-1:0] fall_cnt,
    input logic               rise_ph
);

    logic [RATIO_W:0] gap_q;
    logic             seen_q;
    logic             prev_q;

    // Counts rising-edge samples between output rises.
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= clk_out;
            if (clk_out && !prev_q) begin
                gap_q  <= (RATIO_W+1)'(1);
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + (RATIO_W+1)'(1);
            end
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        rise_cnt <= last_cnt);

    assert_fall_cnt_range_R2: assert property (@(negedge clk_in) disable iff (!rst_n)
        fall_cnt <= last_cnt);

    assert_reset_low_R5: assert property (@(posedge clk_in)
        (!rst_n && mode != MODE_BYPASS) |-> !clk_out);

    assert_even_hold_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode == MODE_EVEN && $past(mode) == MODE_EVEN &&
         $past(rise_cnt) != $past(set_cnt) && $past(rise_cnt) != $past(clr_cnt))
        |-> $stable(rise_ph));

    assert_even_period_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode == MODE_EVEN && seen_q && clk_out && !prev_q)
        |-> (gap_q == ({1'b0, last_cnt} + (RATIO_W+1)'(1))));

endmodule

bind clk_div_int clk_div_int_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .clk_out  (clk_out),
    .mode     (mode),
    .last_cnt (last_cnt),
    .set_cnt  (set_cnt),
    .clr_cnt  (clr_cnt),
    .rise_cnt (rise_cnt),
    .fall_cnt (fall_cnt),
    .rise_ph  (rise_ph)
);

// File: tb/test_clk_div_int.sv
`timescale 1ns/1ps
module test_clk_div_int;

    localparam int RATIO_W = 8;
    localparam int HALF    = 5;
    localparam int PER     = 10;

    logic               clk_in = 1'b0;
    logic               rst_n  = 1'b1;
    logic [RATIO_W-1:0] ratio  = '0;
    logic               clk_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    clk_div_int #(.RATIO_W(RATIO_W)) i_clk_div_int (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .ratio   (ratio),
        .clk_out (clk_out)
    );

    always #HALF clk_in = ~clk_in;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s ratio=%0d actual=%0d expected=%0d", req, what, ratio, act, exp);
        end
    endtask

    task automatic run_ratio(input int n);
        int     eff;
        int     k;
        string  req;
        longint t0, t1, t2, t3, t4, t5;
        eff = (n == 0) ? 1 : n;
        if (eff == 1)          begin k = 1;       req = "R1"; end
        else if (eff % 2 == 0) begin k = eff / 2; req = "R3 R2"; end
        else                   begin k = eff;     req = "R4 R2"; end

        rst_n = 1'b0;
        ratio = RATIO_W'(n);
        @(negedge clk_in); #2;
        check("R5", "out low in reset, clk low", longint'(clk_out), 0);
        @(posedge clk_in); #2;
        check("R5", "out low in reset, clk high", longint'(clk_out), 0);
        @(negedge clk_in); #1;
        rst_n = 1'b1;
        t0 = $time;

        @(posedge clk_out); t1 = $time;
        check("R6", "first rise time", t1 - t0, longint'(HALF - 1 + (k - 1) * PER));
        @(negedge clk_out); t2 = $time;
        check(req, "high time", t2 - t1, longint'(eff * HALF));
        @(posedge clk_out); t3 = $time;
        check(req, "period 1", t3 - t1, longint'(eff * PER));
        @(negedge clk_out); t4 = $time;
        check(req, "high time 2", t4 - t3, longint'(eff * HALF));
        @(posedge clk_out); t5 = $time;
        check(req, "period 2", t5 - t3, longint'(eff * PER));
    endtask

    initial begin
        #1 rst_n = 1'b0;
        for (int n = 0; n <= 17; n++) begin
            run_ratio(n);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * PER);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog ratio=%0d actual=timeout expected=completion", ratio);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule